// File: doc/BRIEF.md
# Per-Scanline Sprite Range Evaluator

This block walks a 128-entry sprite attribute table once per scanline and decides which sprites touch that line and how many 8-pixel slivers the later fetch stage will have to read. A start pulse latches the line number. The scan then reads one table entry per clock, in ascending index order. Each selected sprite index is streamed out as a one-cycle strobe. When the last entry has been judged, a one-cycle done pulse marks the totals as final.

Two limits apply on each line: a cap on the number of selected sprites and a cap on the number of counted slivers. When a limit is hit, a sticky flag is raised. The flag holds until a frame-start clear. The horizontal position is a signed 9-bit value. Its top bit is written through its own strobe, separate from the low byte.

The block keeps one known evaluation quirk. An X field of exactly 0x100 (-256) is charged as if the sprite sat at column 0, so all of its slivers are counted, even though none of its pixels can appear.

Top module: `spr_line_eval`

## Requirements
- R1: After reset, sel_vld, done, range_over and time_over are 0, and sel_total, sliver_total and status are all 0.
- R2: A start pulse accepted while idle scans entries 0 to 127, one per clock. done is high for exactly one cycle, raised by the 129th rising edge after the edge that sampled start.
- R3: A sprite is in range when (line - Y) mod 256 is less than its height. The height is 8 when the size bit is 0 and 16 when it is 1, so a Y near 255 wraps onto low lines.
- R4: In-range sprites are selected in ascending index order, up to 32 per scan. Each selection raises sel_vld for one cycle with its index on sel_idx. A further in-range sprite is not selected and sets range_over, which is status bit 6.
- R5: X is 9-bit two's complement, with bit 8 written through xh_en/xh_val. For a selected sprite, each 8-pixel sliver is counted on sliver_total only if its span overlaps columns 0 to 255.
- R6: A selected sprite whose X field is 0x100 has all of its slivers counted: 1 for size 0, 2 for size 1.
- R7: A sprite with X from -255 to -64 that is in range is still selected and uses a place under the 32 cap, but adds no slivers.
- R8: sliver_total never exceeds 34. A selection that would take it above 34 sets time_over, which is status bit 7, and leaves the total at 34. Reaching exactly 34 does not set the flag.
- R9: range_over and time_over stay set across later scans until frame_clr is sampled high. A flag set in the same cycle as frame_clr remains set. status[5:0] carries sel_total.
- R10: The line number is captured on the start edge, so changing the line input during a scan has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_clr | input | 1 | Clears both sticky flags |
| start | input | 1 | Begins a scan when idle |
| line | input | 8 | Scanline number, captured at start |
| wr_en | input | 1 | Write strobe for X low byte, Y and size |
| wr_idx | input | 7 | Entry index for wr_en |
| wr_xlo | input | 8 | X bits 7..0 |
| wr_y | input | 8 | Y position |
| wr_big | input | 1 | Size select: 0 = 8 px, 1 = 16 px |
| xh_en | input | 1 | Write strobe for X bit 8 |
| xh_idx | input | 7 | Entry index for xh_en |
| xh_val | input | 1 | X bit 8 (sign) |
| sel_vld | output | 1 | One-cycle strobe per selected sprite |
| sel_idx | output | 7 | Index of the selected sprite |
| sel_total | output | 6 | Sprites selected in the current scan |
| sliver_total | output | 6 | Slivers counted in the current scan |
| range_over | output | 1 | Sticky sprite-cap flag |
| time_over | output | 1 | Sticky sliver-cap flag |
| status | output | 8 | {time_over, range_over, sel_total} |
| done | output | 1 | One-cycle end-of-scan pulse |

## Verification
A sticky flag can be set by the tally and cleared by frame_clr in the same cycle. The bench provokes this by placing 33 in-range sprites at indices 0 to 32, so that entry 32 raises range_over on the 34th edge after start, and driving frame_clr into exactly that edge. The bench then judges that range_over reads 1 while time_over, cleared by the same pulse and not being set, reads 0. A later scan without a clear confirms that the flag stays set, and a lone frame_clr confirms that it then drops.

// File: rtl/spr_eval_pkg.sv
package spr_eval_pkg;
  // one attribute word held per sprite (X bit 8 lives in its own array)
  typedef struct packed {
    logic [7:0] xlo;
    logic [7:0] y;
    logic       big;
  } spr_attr_t;
endpackage

// File: rtl/spr_attr_ram.sv
module spr_attr_ram
  import spr_eval_pkg::*;
#(
  parameter int N_SPR = 128,
  localparam int IDX_W = $clog2(N_SPR)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  spr_attr_t        wr_data,
  input  logic             xh_en,
  input  logic [IDX_W-1:0] xh_idx,
  input  logic             xh_val,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output spr_attr_t        rd_data,
  output logic             rd_xh
);
  spr_attr_t mem    [N_SPR];
  logic      xh_mem [N_SPR];

  // two simple dual-port arrays, registered read (read-before-write)
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_data <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (xh_en) xh_mem[xh_idx] <= xh_val;
    if (rd_en) rd_xh <= xh_mem[rd_idx];
  end
endmodule

// File: rtl/spr_scan_ctrl.sv
module spr_scan_ctrl #(
  parameter int N_SPR = 128,
  localparam int IDX_W = $clog2(N_SPR)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [7:0]       line,
  output logic             accept,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       line_q,
  output logic             p_vld,
  output logic [IDX_W-1:0] p_idx,
  output logic             p_last
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SPR - 1);

  logic             busy;
  logic [IDX_W-1:0] idx;

  // a new scan only begins once the read pipeline is empty
  assign accept = start && !busy && !p_vld;
  assign rd_en  = busy;
  assign rd_idx = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      idx    <= '0;
      line_q <= '0;
      p_vld  <= 1'b0;
      p_idx  <= '0;
      p_last <= 1'b0;
    end else begin
      if (accept) begin
        busy   <= 1'b1;
        idx    <= '0;
        line_q <= line;
      end else if (busy) begin
        idx <= idx + 1'b1;
        if (idx == LAST) busy <= 1'b0;
      end
      // align index with the registered RAM output
      p_vld  <= busy;
      p_idx  <= idx;
      p_last <= busy && (idx == LAST);
    end
  end

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && idx != LAST) |=> (busy && idx == $past(idx) + 1'b1));

  // R10
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !accept) |=> $stable(line_q));
endmodule

// File: rtl/spr_line_test.sv
module spr_line_test
  import spr_eval_pkg::*;
#(
  parameter int SMALL_W = 8,
  parameter int LARGE_W = 16,
  localparam int MAX_SL = LARGE_W / 8,
  localparam int SL_W   = $clog2(MAX_SL + 1)
) (
  input  logic [7:0]      line,
  input  spr_attr_t       attr,
  input  logic            xh,
  output logic            in_rng,
  output logic [SL_W-1:0] nsl
);
  logic [7:0]         dy;
  int                 h_px;
  int                 need_sl;
  logic               at_wrap;
  logic signed [10:0] xs;
  logic [MAX_SL-1:0]  hit;

  assign dy      = line - attr.y;
  assign xs      = {{2{xh}}, xh, attr.xlo};
  // X field 0x100 is charged as if it sat at column 0
  assign at_wrap = xh && (attr.xlo == 8'h00);

  always_comb begin
    h_px    = attr.big ? LARGE_W : SMALL_W;
    need_sl = h_px / 8;
    in_rng  = int'(dy) < h_px;
  end

  for (genvar k = 0; k < MAX_SL; k++) begin : g_sliver
    logic signed [10:0] left;
    assign left   = xs + 11'(8 * k);
    assign hit[k] = (k < need_sl) &&
                    (at_wrap || ((left > -11'sd8) && (left < 11'sd256)));
  end

  always_comb begin
    nsl = '0;
    for (int k = 0; k < MAX_SL; k++) nsl = nsl + SL_W'(hit[k]);
  end

  // R6
  wrap_full_chk: assert final (!(at_wrap && attr.big) || int'(nsl) == LARGE_W / 8);
endmodule

// File: rtl/spr_tally.sv
module spr_tally #(
  parameter int N_SPR   = 128,
  parameter int MAX_SEL = 32,
  parameter int MAX_SLV = 34,
  parameter int SL_W    = 2,
  parameter int CNT_W   = 6,
  localparam int IDX_W  = $clog2(N_SPR)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_clr,
  input  logic             clr_cnt,
  input  logic             p_vld,
  input  logic [IDX_W-1:0] p_idx,
  input  logic             p_last,
  input  logic             in_rng,
  input  logic [SL_W-1:0]  nsl,
  output logic             sel_vld,
  output logic [IDX_W-1:0] sel_idx,
  output logic [CNT_W-1:0] sel_cnt,
  output logic [CNT_W-1:0] slv_cnt,
  output logic             range_over,
  output logic             time_over,
  output logic             done
);
  logic             room;
  logic             take;
  logic             rng_set;
  logic             tm_set;
  logic [CNT_W:0]   slv_sum;

  assign room    = sel_cnt < CNT_W'(MAX_SEL);
  assign take    = p_vld && in_rng && room;
  assign rng_set = p_vld && in_rng && !room;
  assign slv_sum = (CNT_W+1)'(slv_cnt) + (CNT_W+1)'(nsl);
  assign tm_set  = take && (slv_sum > (CNT_W+1)'(MAX_SLV));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_vld    <= 1'b0;
      sel_idx    <= '0;
      sel_cnt    <= '0;
      slv_cnt    <= '0;
      range_over <= 1'b0;
      time_over  <= 1'b0;
      done       <= 1'b0;
    end else begin
      sel_vld <= take;
      done    <= p_vld && p_last;
      if (take) sel_idx <= p_idx;
      if (clr_cnt) begin
        sel_cnt <= '0;
        slv_cnt <= '0;
      end else if (take) begin
        sel_cnt <= sel_cnt + 1'b1;
        slv_cnt <= tm_set ? CNT_W'(MAX_SLV) : slv_sum[CNT_W-1:0];
      end
      // a set in the clearing cycle wins
      range_over <= rng_set | (range_over & ~frame_clr);
      time_over  <= tm_set  | (time_over  & ~frame_clr);
    end
  end

  // R4
  sel_cap_chk: assert property (@(posedge clk) disable iff (rst)
    sel_cnt <= CNT_W'(MAX_SEL));

  // R8
  slv_cap_chk: assert property (@(posedge clk) disable iff (rst)
    slv_cnt <= CNT_W'(MAX_SLV));

  // R9
  range_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (range_over && !frame_clr) |=> range_over);

  // R9
  time_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (time_over && !frame_clr) |=> time_over);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  sel_order_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_vld && take) |=> (sel_idx > $past(sel_idx)));
endmodule

// File: rtl/spr_line_eval.sv
module spr_line_eval
  import spr_eval_pkg::*;
#(
  parameter int N_SPR   = 128,
  parameter int MAX_SEL = 32,
  parameter int MAX_SLV = 34,
  parameter int SMALL_W = 8,
  parameter int LARGE_W = 16,
  localparam int IDX_W  = $clog2(N_SPR),
  localparam int SL_W   = $clog2(LARGE_W / 8 + 1),
  localparam int CNT_W  = $clog2((MAX_SEL > MAX_SLV ? MAX_SEL : MAX_SLV) + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_clr,
  input  logic             start,
  input  logic [7:0]       line,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_xlo,
  input  logic [7:0]       wr_y,
  input  logic             wr_big,
  input  logic             xh_en,
  input  logic [IDX_W-1:0] xh_idx,
  input  logic             xh_val,
  output logic             sel_vld,
  output logic [IDX_W-1:0] sel_idx,
  output logic [CNT_W-1:0] sel_total,
  output logic [CNT_W-1:0] sliver_total,
  output logic             range_over,
  output logic             time_over,
  output logic [CNT_W+1:0] status,
  output logic             done
);
  spr_attr_t        wdata, rdata;
  logic             rxh;
  logic             accept, rd_en, p_vld, p_last, in_rng;
  logic [IDX_W-1:0] rd_idx, p_idx;
  logic [7:0]       line_q;
  logic [SL_W-1:0]  nsl;

  assign wdata = '{xlo: wr_xlo, y: wr_y, big: wr_big};

  spr_attr_ram #(.N_SPR(N_SPR)) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wdata),
    .xh_en(xh_en), .xh_idx(xh_idx), .xh_val(xh_val),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rdata), .rd_xh(rxh)
  );

  spr_scan_ctrl #(.N_SPR(N_SPR)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .line(line), .accept(accept),
    .rd_en(rd_en), .rd_idx(rd_idx), .line_q(line_q),
    .p_vld(p_vld), .p_idx(p_idx), .p_last(p_last)
  );

  spr_line_test #(.SMALL_W(SMALL_W), .LARGE_W(LARGE_W)) u_test (
    .line(line_q), .attr(rdata), .xh(rxh), .in_rng(in_rng), .nsl(nsl)
  );

  spr_tally #(
    .N_SPR(N_SPR), .MAX_SEL(MAX_SEL), .MAX_SLV(MAX_SLV),
    .SL_W(SL_W), .CNT_W(CNT_W)
  ) u_tally (
    .clk(clk), .rst(rst), .frame_clr(frame_clr), .clr_cnt(accept),
    .p_vld(p_vld), .p_idx(p_idx), .p_last(p_last),
    .in_rng(in_rng), .nsl(nsl),
    .sel_vld(sel_vld), .sel_idx(sel_idx), .sel_cnt(sel_total),
    .slv_cnt(sliver_total), .range_over(range_over),
    .time_over(time_over), .done(done)
  );

  assign status = {time_over, range_over, sel_total};
endmodule

// File: tb/spr_line_eval_tb.sv
module spr_line_eval_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_clr = 1'b0, start = 1'b0;
  logic [7:0] line = '0;
  logic       wr_en = 1'b0, xh_en = 1'b0, xh_val = 1'b0, wr_big = 1'b0;
  logic [6:0] wr_idx = '0, xh_idx = '0;
  logic [7:0] wr_xlo = '0, wr_y = '0;
  logic       sel_vld, range_over, time_over, done;
  logic [6:0] sel_idx;
  logic [5:0] sel_total, sliver_total;
  logic [7:0] status;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int got_ids[64];
  int n_got = 0;
  int exp_q[$];

  always #4 clk = ~clk;  // 125 MHz

  spr_line_eval u_dut (
    .clk(clk), .rst(rst), .frame_clr(frame_clr), .start(start), .line(line),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_xlo(wr_xlo), .wr_y(wr_y),
    .wr_big(wr_big), .xh_en(xh_en), .xh_idx(xh_idx), .xh_val(xh_val),
    .sel_vld(sel_vld), .sel_idx(sel_idx), .sel_total(sel_total),
    .sliver_total(sliver_total), .range_over(range_over),
    .time_over(time_over), .status(status), .done(done)
  );

  always @(negedge clk) begin
    if (sel_vld && n_got < 64) begin
      got_ids[n_got] = int'(sel_idx);
      n_got++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: cycles %0d expected < %0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_spr(int idx, int x9, int y, bit big);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 7'(idx); wr_xlo = 8'(x9); wr_y = 8'(y); wr_big = big;
    xh_en = 1'b1; xh_idx = 7'(idx); xh_val = x9[8];
    @(negedge clk);
    wr_en = 1'b0; xh_en = 1'b0;
  endtask

  task automatic clear_table();
    for (int i = 0; i < 128; i++) wr_spr(i, 0, 200, 1'b0);
  endtask

  // starts a scan; optionally moves line or pulses frame_clr at a set edge
  task automatic run_scan(string req, int ln, int clr_edge, int new_line);
    int n;
    @(negedge clk);
    n_got = 0; line = 8'(ln); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 400) begin
      if (n + 1 == clr_edge) frame_clr = 1'b1;
      if (n == 2 && new_line >= 0) line = 8'(new_line);
      @(posedge clk); n++;
      @(negedge clk);
      frame_clr = 1'b0;
    end
    chk({req, " done edge"}, n, 129);
    @(negedge clk);
    chk({req, " done one cycle"}, int'(done), 0);
  endtask

  task automatic check_list(string req, int slv, int stat);
    chk({req, " select count"}, n_got, exp_q.size());
    for (int i = 0; i < exp_q.size() && i < n_got; i++)
      chk({req, " select index"}, got_ids[i], exp_q[i]);
    chk({req, " sliver_total"}, int'(sliver_total), slv);
    chk({req, " status"}, int'(status), stat);
  endtask

  task automatic t_reset();
    chk("R1 sel_vld", int'(sel_vld), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 status", int'(status), 0);
    chk("R1 sliver_total", int'(sliver_total), 0);
    chk("R1 flags", int'(range_over) + int'(time_over), 0);
  endtask

  task automatic load_basic();
    clear_table();
    wr_spr(5, 20, 10, 1'b0);
    wr_spr(9, 100, 3, 1'b1);
    wr_spr(12, 0, 3, 1'b0);
    wr_spr(20, 0, 2, 1'b0);
    wr_spr(40, 250, 0, 1'b1);
    wr_spr(60, 0, 250, 1'b1);
    wr_spr(61, -4, 251, 1'b1);
    exp_q = '{5, 9, 12, 40, 61};
  endtask

  // R3 R5: range rule with wrap, edge slivers
  task automatic t_basic();
    load_basic();
    run_scan("R2", 10, -1, -1);
    check_list("R3 R5 basic", 7, 8'h05);
  endtask

  // R10: line changes mid-scan
  task automatic t_latch();
    run_scan("R2", 10, -1, 100);
    check_list("R10 line latch", 7, 8'h05);
  endtask

  // R6 R7: wrap quirk and left-off-screen sprites
  task automatic t_quirk();
    clear_table();
    wr_spr(3, 256, 10, 1'b1);
    wr_spr(4, -255, 10, 1'b1);
    wr_spr(6, -64, 10, 1'b0);
    wr_spr(7, -9, 10, 1'b0);
    wr_spr(8, -7, 10, 1'b0);
    wr_spr(10, 255, 10, 1'b1);
    wr_spr(11, -8, 10, 1'b1);
    exp_q = '{3, 4, 6, 7, 8, 10, 11};
    run_scan("R2", 10, -1, -1);
    check_list("R6 R7 quirk", 5, 8'h07);
  endtask

  // R8: exactly 34, then one sprite more
  task automatic t_time();
    clear_table();
    exp_q = {};
    for (int i = 0; i < 17; i++) begin
      wr_spr(i, 16, 10, 1'b1);
      exp_q.push_back(i);
    end
    run_scan("R2", 10, -1, -1);
    check_list("R8 at limit", 34, 17);
    wr_spr(17, 16, 10, 1'b1);
    exp_q.push_back(17);
    run_scan("R2", 10, -1, -1);
    check_list("R8 over limit", 34, 8'h92);
    chk("R8 time_over", int'(time_over), 1);
  endtask

  // R4 R9: range-over set in the same cycle as frame_clr
  task automatic t_range();
    clear_table();
    exp_q = {};
    for (int i = 0; i < 33; i++) begin
      wr_spr(i, 0, 10, 1'b0);
      if (i < 32) exp_q.push_back(i);
    end
    run_scan("R2", 10, 34, -1);
    check_list("R4 R9 cap with clear", 32, 8'h60);
    chk("R9 range_over kept", int'(range_over), 1);
    chk("R9 time_over cleared", int'(time_over), 0);
    clear_table();
    wr_spr(50, 30, 10, 1'b0);
    exp_q = '{50};
    run_scan("R2", 10, -1, -1);
    check_list("R9 sticky", 1, 8'h41);
    @(negedge clk); frame_clr = 1'b1;
    @(negedge clk); frame_clr = 1'b0;
    chk("R9 clear", int'(status), 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_latch();
    t_quirk();
    t_time();
    t_range();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule